// File: doc/BRIEF.md
# Dual Interval Timer with Interrupt Registers

This peripheral holds two identical down-counting interval timers, a free-running time counter and one shared set of interrupt registers: sticky raw status, enable mask and write-one-to-clear acknowledge. Software reaches everything through a 32-bit register port that only accepts word-aligned accesses. The block drives a single level-sensitive interrupt line.

Each timer has a reload value, a current count and a control word. The control word holds an operation code and a tick-source code. The block does not generate clocks. It receives four tick-enable strobes and picks one per timer. A separate strobe advances the time counter once per 10 ns period of the surrounding system.

The register offsets are part of the software contract and are fixed:

| Offset | Register |
|---|---|
| 0x00 | timer 0 reload |
| 0x04 | timer 0 count |
| 0x08 | timer 0 control |
| 0x10 | timer 1 reload |
| 0x14 | timer 1 count |
| 0x18 | timer 1 control |
| 0x38 | time |
| 0x48 | mask |
| 0x4C | acknowledge |
| 0x50 | raw status |
| 0x54 | masked status |

Top module: `duo_interval_timer`

## Requirements
- R1: After synchronous reset, the following all read 0 and `irq` is low: both counts, both reload values, both control words, raw status, mask and time.
- R2: A control write whose operation field (bits [1:0]) is 0 copies the reload value into the count. The count then stays put.
- R3: Operation 1 (hold) freezes the count. The illegal operation 3 behaves like hold.
- R4: Operation 2 (run) changes the count only on each selected tick. A tick at a nonzero count decrements it. A tick at zero reloads the reload value and raises that timer's expiry for one cycle, so the period is reload+1 ticks.
- R5: Tick-source field bits [4:2] values 4, 5, 6 and 7 select `tick_src[0]`, `[1]`, `[2]` and `[3]`. Values 0 to 3 mean an external or disabled source and never advance the count.
- R6: Expiry of timer 0 sets raw bit 0 and expiry of timer 1 sets raw bit 1. The bit is set at the second clock edge after the tick that caused the expiry. It stays set until acknowledged.
- R7: Masked status (0x54) reads raw AND mask (mask bits [1:0]). `irq` is high exactly when any masked bit is set.
- R8: An acknowledge write clears each raw bit written as 1 and leaves bits written as 0 untouched. The acknowledge register reads 0. An expiry in the same cycle as an acknowledge of its bit leaves the bit set.
- R9: The time register increments by one at every clock edge that sees `tick_10ns` high.
- R10: An access whose `bus_addr[1:0]` is nonzero is ignored: a write changes no register and a read returns 0.
- R11: A mask write takes effect on `irq` at the first clock edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 7 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; combinational during a read, otherwise 0 |
| tick_src | input | 4 | Selectable tick-enable strobes for the timers |
| tick_10ns | input | 1 | Advance strobe for the time counter |
| irq | output | 1 | Level interrupt, OR of masked status |

## Verification
Assertions check these rules on every cycle:
- a held or non-running count never moves;
- a ticked nonzero count drops by exactly one;
- an expiry always leaves the count equal to the reload value;
- a raw bit is always set after an expiry and never clears without an acknowledge;
- the time counter steps by one on each strobe.

Only the bench scenarios can show the following:
- the tick-source mapping and the disabled source codes;
- misaligned accesses having no effect;
- the one-edge latency of a mask write on `irq`;
- an expiry winning over a simultaneous acknowledge.

The bench's cycle-by-cycle reference model compares the read data and `irq` on every clock.

// File: rtl/dit_pkg.sv
package dit_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 7;
    localparam int N_TMR  = 2;
    localparam int N_SRC  = 4;
    localparam int CTRL_W = 5;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_HOLD = 2'd1,
        OP_RUN  = 2'd2,
        OP_BAD  = 2'd3
    } tmr_op_e;

    typedef struct packed {
        logic [2:0] src;
        tmr_op_e    op;
    } tmr_ctrl_t;

    localparam logic [ADDR_W-1:0] A_TIME   = 7'h38;
    localparam logic [ADDR_W-1:0] A_MASK   = 7'h48;
    localparam logic [ADDR_W-1:0] A_ACK    = 7'h4C;
    localparam logic [ADDR_W-1:0] A_RAW    = 7'h50;
    localparam logic [ADDR_W-1:0] A_MASKED = 7'h54;

    function automatic logic [ADDR_W-1:0] tmr_addr(input int t, input int reg_idx);
        return ADDR_W'(t * 16 + reg_idx * 4);
    endfunction

    function automatic logic pick_tick(input logic [2:0] src, input logic [N_SRC-1:0] ticks);
        return src[2] & ticks[src[1:0]];
    endfunction

endpackage

// File: rtl/dit_timer.sv
module dit_timer
    import dit_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              div_wr,
    input  logic              ctrl_wr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [N_SRC-1:0]  tick_src,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  reload,
    output tmr_ctrl_t         ctrl,
    output logic              expire
);
    logic [CNT_W-1:0] cnt_q, div_q;
    tmr_ctrl_t        ctrl_q;
    logic             exp_q;
    logic             tick_now;
    logic             running;

    assign tick_now = pick_tick(ctrl_q.src, tick_src);
    assign running  = (ctrl_q.op == OP_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            div_q  <= '0;
            ctrl_q <= '0;
            exp_q  <= 1'b0;
        end else begin
            exp_q <= 1'b0;
            if (div_wr)
                div_q <= wdata[CNT_W-1:0];
            if (ctrl_wr) begin
                ctrl_q <= tmr_ctrl_t'(wdata[CTRL_W-1:0]);
                if (wdata[1:0] == OP_LOAD)
                    cnt_q <= div_q;
            end else if (running && tick_now) begin
                if (cnt_q == '0) begin
                    cnt_q <= div_q;
                    exp_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign count  = cnt_q;
    assign reload = div_q;
    assign ctrl   = ctrl_q;
    assign expire = exp_q;

    // R3: outside run mode, and without a control write, the count is frozen
    assert_hold_frozen_R3: assert property (@(posedge clk) disable iff (rst)
        (!running && !ctrl_wr) |=> $stable(cnt_q));

    // R4: a tick on a nonzero running count decrements it by exactly one
    assert_step_down_R4: assert property (@(posedge clk) disable iff (rst)
        (running && tick_now && !ctrl_wr && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R4: an expiry leaves the reload value in the count
    assert_reload_on_expire_R4: assert property (@(posedge clk) disable iff (rst)
        exp_q |-> (cnt_q == $past(div_q)));

endmodule

// File: rtl/dit_irq_regs.sv
module dit_irq_regs
    import dit_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mask_wr,
    input  logic             ack_wr,
    input  logic [N_TMR-1:0] wbits,
    input  logic [N_TMR-1:0] expire,
    output logic [N_TMR-1:0] raw,
    output logic [N_TMR-1:0] mask,
    output logic             irq
);
    logic [N_TMR-1:0] raw_q, mask_q, clr;

    assign clr = ack_wr ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q <= (raw_q & ~clr) | expire;
            if (mask_wr)
                mask_q <= wbits;
        end
    end

    assign raw  = raw_q;
    assign mask = mask_q;
    assign irq  = |(raw_q & mask_q);

    for (genvar i = 0; i < N_TMR; i++) begin : g_bit_chk
        // R6: an expiry always leaves its raw bit set
        assert_expire_sets_R6: assert property (@(posedge clk) disable iff (rst)
            expire[i] |=> raw_q[i]);
        // R8: a raw bit only falls through an acknowledge of that bit
        assert_sticky_until_ack_R8: assert property (@(posedge clk) disable iff (rst)
            (raw_q[i] && !clr[i]) |=> raw_q[i]);
    end

endmodule

// File: rtl/duo_interval_timer.sv
module duo_interval_timer
    import dit_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [6:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [3:0]        tick_src,
    input  logic              tick_10ns,
    output logic              irq
);
    logic             aligned, wr_en, rd_en;
    logic [N_TMR-1:0] div_wr, ctrl_wr, expire_w, raw_w, mask_w;
    logic [CNT_W-1:0] cnt_w [N_TMR];
    logic [CNT_W-1:0] div_w [N_TMR];
    tmr_ctrl_t        ctrl_w [N_TMR];
    logic [TIME_W-1:0] time_q;
    logic [BUS_W-1:0]  rd_val;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_en   = bus_sel & bus_wr & aligned;
    assign rd_en   = bus_sel & ~bus_wr & aligned;

    for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
        assign div_wr[t]  = wr_en && (bus_addr == tmr_addr(t, 0));
        assign ctrl_wr[t] = wr_en && (bus_addr == tmr_addr(t, 2));
        dit_timer #(.CNT_W(CNT_W)) u_tmr (
            .clk     (clk),
            .rst     (rst),
            .div_wr  (div_wr[t]),
            .ctrl_wr (ctrl_wr[t]),
            .wdata   (bus_wdata),
            .tick_src(tick_src),
            .count   (cnt_w[t]),
            .reload  (div_w[t]),
            .ctrl    (ctrl_w[t]),
            .expire  (expire_w[t])
        );
    end

    dit_irq_regs u_irq (
        .clk     (clk),
        .rst     (rst),
        .mask_wr (wr_en && bus_addr == A_MASK),
        .ack_wr  (wr_en && bus_addr == A_ACK),
        .wbits   (bus_wdata[N_TMR-1:0]),
        .expire  (expire_w),
        .raw     (raw_w),
        .mask    (mask_w),
        .irq     (irq)
    );

    always_ff @(posedge clk) begin
        if (rst)
            time_q <= '0;
        else if (tick_10ns)
            time_q <= time_q + 1'b1;
    end

    always_comb begin
        rd_val = '0;
        if (rd_en) begin
            for (int t = 0; t < N_TMR; t++) begin
                if (bus_addr == tmr_addr(t, 0)) rd_val = BUS_W'(div_w[t]);
                if (bus_addr == tmr_addr(t, 1)) rd_val = BUS_W'(cnt_w[t]);
                if (bus_addr == tmr_addr(t, 2)) rd_val = BUS_W'(ctrl_w[t]);
            end
            case (bus_addr)
                A_TIME:   rd_val = BUS_W'(time_q);
                A_MASK:   rd_val = BUS_W'(mask_w);
                A_RAW:    rd_val = BUS_W'(raw_w);
                A_MASKED: rd_val = BUS_W'(raw_w & mask_w);
                default:  ;
            endcase
        end
    end

    assign bus_rdata = rd_val;

    // R9: the time counter moves by exactly one per strobe
    assert_time_step_R9: assert property (@(posedge clk) disable iff (rst)
        tick_10ns |=> (time_q == $past(time_q) + 1'b1));

    // R10: no read data leaves the block for a misaligned access
    assert_misaligned_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !aligned) |-> (bus_rdata == '0));

endmodule

// File: tb/duo_interval_timer_test.sv
module duo_interval_timer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  tick_src = 4'b0001;
    logic        tick_10ns = 1'b1;
    logic        irq;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    duo_interval_timer uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_src(tick_src), .tick_10ns(tick_10ns), .irq(irq)
    );

    // Reference model state
    logic [31:0] m_div [2] = '{0, 0};
    logic [31:0] m_cnt [2] = '{0, 0};
    logic [4:0]  m_ctrl[2] = '{0, 0};
    logic [1:0]  m_exp = '0, m_raw = '0, m_mask = '0;
    logic [31:0] m_time = '0;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 2; i++) begin
                m_div[i] = 0; m_cnt[i] = 0; m_ctrl[i] = 0;
            end
            m_exp = 0; m_raw = 0; m_mask = 0; m_time = 0;
        end else begin
            logic wok;
            logic [1:0] nexp;
            wok = bus_sel && bus_wr && (bus_addr[1:0] == 2'b00);
            m_raw = (m_raw & ~((wok && bus_addr == 7'h4C) ? bus_wdata[1:0] : 2'b00)) | m_exp;
            nexp = 2'b00;
            for (int i = 0; i < 2; i++) begin
                logic tk;
                tk = m_ctrl[i][4] && tick_src[m_ctrl[i][3:2]];
                if (wok && bus_addr == 7'(i * 16 + 8)) begin
                    m_ctrl[i] = bus_wdata[4:0];
                    if (bus_wdata[1:0] == 2'd0) m_cnt[i] = m_div[i];
                end else if (m_ctrl[i][1:0] == 2'd2 && tk) begin
                    if (m_cnt[i] == 0) begin
                        m_cnt[i] = m_div[i];
                        nexp[i] = 1'b1;
                    end else begin
                        m_cnt[i] = m_cnt[i] - 1;
                    end
                end
                if (wok && bus_addr == 7'(i * 16)) m_div[i] = bus_wdata;
            end
            m_exp = nexp;
            if (wok && bus_addr == 7'h48) m_mask = bus_wdata[1:0];
            if (tick_10ns) m_time = m_time + 1;
        end
    end

    function automatic logic [31:0] model_read(input logic [6:0] a);
        if (!(bus_sel && !bus_wr) || a[1:0] != 2'b00) return 0;
        case (a)
            7'h00: return m_div[0];
            7'h04: return m_cnt[0];
            7'h08: return 32'(m_ctrl[0]);
            7'h10: return m_div[1];
            7'h14: return m_cnt[1];
            7'h18: return 32'(m_ctrl[1]);
            7'h38: return m_time;
            7'h48: return 32'(m_mask);
            7'h50: return 32'(m_raw);
            7'h54: return 32'(m_raw & m_mask);
            default: return 0;
        endcase
    endfunction

    function automatic string req_of(input logic [6:0] a);
        if (a[1:0] != 2'b00) return "R10";
        case (a)
            7'h04, 7'h14: return "R4";
            7'h00, 7'h08, 7'h10, 7'h18: return "R2";
            7'h38: return "R9";
            7'h50: return "R6";
            7'h48, 7'h54: return "R7";
            7'h4C: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at cycle %0d", req, got, exp, cyc);
        end
    endtask

    // Every-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(req_of(bus_addr), bus_rdata, model_read(bus_addr));
            check("R7", 32'(irq), 32'(|(m_raw & m_mask)));
        end
    end

    // Tick strobes: src0 every cycle, src1 every 2nd, src2 every 3rd, src3 every 5th
    always @(negedge clk) begin
        #1;
        cyc++;
        tick_src = {cyc % 5 == 0, cyc % 3 == 0, cyc % 2 == 0, 1'b1};
    end

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_wr = 0;
    endtask

    task automatic rd(input logic [6:0] a);
        @(negedge clk); #1;
        bus_sel = 1; bus_wr = 0; bus_addr = a;
    endtask

    task automatic chk_rd(input string req, input logic [6:0] a, input logic [31:0] exp);
        rd(a);
        @(negedge clk);
        check(req, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v, t0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1 rst = 0;

        // R1 reset state
        chk_rd("R1", 7'h04, 0);
        chk_rd("R1", 7'h14, 0);
        chk_rd("R1", 7'h50, 0);
        chk_rd("R1", 7'h48, 0);
        chk_rd("R1", 7'h08, 0);
        check("R1", 32'(irq), 0);

        // R2 load: reload 5, tick source 4, op load
        wr(7'h00, 5);
        wr(7'h08, 32'h10);
        chk_rd("R2", 7'h04, 5);
        idle(6);
        check("R2", bus_rdata, 5);

        // R4/R6/R7 run with mask bit 0
        wr(7'h48, 1);
        wr(7'h08, 32'h12);
        rd(7'h04);
        idle(20);
        chk_rd("R6", 7'h50, 1);
        check("R7", 32'(irq), 1);
        chk_rd("R7", 7'h54, 1);

        // R3 hold freezes, illegal op behaves like hold
        wr(7'h08, 32'h11);
        rd(7'h04); @(negedge clk); v = bus_rdata;
        idle(7);
        check("R3", bus_rdata, v);
        wr(7'h08, 32'h13);
        rd(7'h04); idle(9);
        check("R3", bus_rdata, v);

        // R8 acknowledge clears, reads as 0
        wr(7'h4C, 1);
        chk_rd("R8", 7'h50, 0);
        check("R8", 32'(irq), 0);
        chk_rd("R8", 7'h4C, 0);

        // R5 disabled source code 1 never advances
        wr(7'h10, 3);
        wr(7'h18, 32'h04);
        wr(7'h18, 32'h06);
        rd(7'h14); idle(10);
        check("R5", bus_rdata, 3);
        // R5 source 7 -> strobe 3, then source 5 -> strobe 1
        wr(7'h48, 3);
        wr(7'h18, 32'h1E);
        rd(7'h14); idle(40);
        wr(7'h18, 32'h16);
        rd(7'h14); idle(30);
        chk_rd("R5", 7'h50, 2);

        // R10 misaligned write ignored, misaligned read returns 0
        wr(7'h49, 0);
        chk_rd("R10", 7'h48, 3);
        chk_rd("R10", 7'h4A, 0);

        // R8 expiry wins over ack: reload 0 expires on every cycle
        wr(7'h18, 32'h15);
        wr(7'h00, 0);
        wr(7'h08, 32'h10);
        wr(7'h08, 32'h12);
        idle(3);
        wr(7'h4C, 1);
        check("R8", bus_rdata, 0);
        chk_rd("R8", 7'h50, 3);

        // R11 mask write reaches irq at the next edge
        wr(7'h08, 32'h11);
        wr(7'h4C, 2);
        wr(7'h48, 0);
        idle(2);
        check("R11", 32'(irq), 0);
        wr(7'h48, 1);
        check("R11", 32'(irq), 1);

        // R9 time counter, strobe high every cycle
        rd(7'h38); @(negedge clk); t0 = bus_rdata;
        idle(10);
        check("R9", bus_rdata - t0, 10);
        @(negedge clk); #1 tick_10ns = 0;
        idle(1); v = bus_rdata; idle(4);
        check("R9", bus_rdata, v);
        #1 tick_10ns = 1;
        idle(5);

        finish_run();
    end

endmodule